// File: doc/BRIEF.md
# Real-Time Clock with Seconds Alarm

This peripheral keeps time as a 32-bit seconds count and a milliseconds count, and sits on a simple 32-bit register bus. A free-running pacer divides the system clock into 32 kHz-like ticks. Every eight ticks it copies the live seconds and milliseconds into bus-side holding registers. During the last tick of each eight-tick frame it reports itself busy, and writes to the time-keeping registers are refused in that window. Software waits for busy to fall and then has most of a frame to update the time or the alarm safely.

Reading the milliseconds register also copies the matching posted seconds into a shadow register. A following read of the shadow register then returns a coherent seconds/milliseconds pair. A single seconds alarm compares against the seconds counter. On a match it latches a sticky status bit, which software clears by writing a one to it. A level interrupt is raised whenever a status bit and its mask bit are both set.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset every readable register (busy 0x004, seconds 0x008, shadow 0x00C, milliseconds 0x010, alarm 0x014, mask 0x028, status 0x02C) reads zero until the first posting, and `irq` is low.
- R2: The milliseconds counter advances once every CLKS_PER_MS clocks and counts 0 to MS_PER_SEC-1. When it wraps to 0 the seconds counter increments, and seconds wrap from 0xFFFFFFFF to 0.
- R3: Busy (bit 0 of 0x004) is high for the last tick period, of CLKS_PER_TICK clocks, in each frame of TICKS_PER_POST ticks counted from reset. The values read at 0x008 and 0x010 are the live counters captured as busy falls, so consecutive postings differ by exactly TICKS_PER_POST*CLKS_PER_TICK/CLKS_PER_MS milliseconds of total time.
- R4: A read of 0x010 loads the seconds value posted with that milliseconds value into the shadow register at 0x00C. The shadow register changes on no other event.
- R5: A write to seconds (0x008) or alarm (0x014) takes effect when busy is clear and is ignored when busy is set.
- R6: Status bit 0 is set in the cycle the seconds counter becomes equal to a nonzero alarm value. It stays set whatever the mask, until it is cleared.
- R7: An alarm value of zero never sets status bit 0, including when the seconds counter wraps to zero.
- R8: Status (0x02C) is write-one-to-clear: each written 1 clears its bit and each written 0 leaves its bit unchanged.
- R9: `irq` is high exactly while some status bit and the same mask bit are both set. Mask and status share one layout: bit 0 seconds alarm 0, bit 1 seconds alarm 1, bit 2 millisecond alarm, bit 3 seconds countdown, bit 4 millisecond countdown. Only bit 0 can become set.
- R10: Read data appears on `bus_rdata` the cycle after the read request. Unmapped offsets read zero. Writes to busy, shadow and milliseconds change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Level interrupt, high while a masked status bit is set |

## Verification
The hardest case to reach is a write that lands inside the two-clock busy window, because the window is visible only through a registered register read. The bench reads busy on every cycle. When it first sees busy go from zero to one, it knows the next cycle is the last busy cycle and places the write there. It then checks that the alarm and seconds values kept their old contents. Seconds wrapping onto a zero alarm is reached by loading 0xFFFFFFFF into the seconds counter while the alarm is zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BUS_DW = 32;
    localparam int ADDR_W = 12;
    localparam int IRQ_W  = 5;
    localparam int IRQ_SEC0 = 0;

    localparam logic [ADDR_W-1:0] OFS_BUSY   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_MS     = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_ALARM  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h02C;

    typedef enum logic [2:0] {
        REG_NONE, REG_BUSY, REG_SEC, REG_SHADOW,
        REG_MS, REG_ALARM, REG_MASK, REG_STAT
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [BUS_DW-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_BUSY:   return REG_BUSY;
            OFS_SEC:    return REG_SEC;
            OFS_SHADOW: return REG_SHADOW;
            OFS_MS:     return REG_MS;
            OFS_ALARM:  return REG_ALARM;
            OFS_MASK:   return REG_MASK;
            OFS_STAT:   return REG_STAT;
            default:    return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rtc_pacer.sv
module rtc_pacer #(
    parameter int CLKS_PER_TICK  = 6104,
    parameter int TICKS_PER_POST = 8
) (
    input  logic clk,
    input  logic rst,
    output logic busy,
    output logic post
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam int PW = (TICKS_PER_POST > 1) ? $clog2(TICKS_PER_POST) : 1;
    localparam logic [CW-1:0] CLK_LAST  = CW'(CLKS_PER_TICK - 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(TICKS_PER_POST - 1);

    logic [CW-1:0] clk_cnt;
    logic [PW-1:0] phase;
    logic          tick;

    assign tick = (clk_cnt == CLK_LAST);
    assign busy = (phase == PHASE_LAST);
    assign post = tick && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_cnt <= '0;
            phase   <= '0;
        end else begin
            clk_cnt <= tick ? '0 : clk_cnt + 1'b1;
            if (tick)
                phase <= busy ? '0 : phase + 1'b1;
        end
    end

    // R3: busy only ends on the posting cycle
    a_r3_busy_ends_on_post: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(post));

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int CLKS_PER_MS = 200000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_W       = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_wr,
    input  logic [SEC_W-1:0] sec_wdata,
    input  logic             post,
    output logic [SEC_W-1:0] sec_q,
    output logic [SEC_W-1:0] sec_next,
    output logic             sec_upd,
    output logic [$clog2(MS_PER_SEC)-1:0] post_ms,
    output logic [SEC_W-1:0] post_sec
);
    localparam int MW = $clog2(MS_PER_SEC);
    localparam int DW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLKS_PER_MS - 1);
    localparam logic [MW-1:0] MS_LAST  = MW'(MS_PER_SEC - 1);

    logic [DW-1:0] div_cnt;
    logic [MW-1:0] ms_q;
    logic          ms_tick;
    logic          ms_wrap;

    assign ms_tick  = (div_cnt == DIV_LAST);
    assign ms_wrap  = ms_tick && (ms_q == MS_LAST);
    assign sec_upd  = sec_wr || ms_wrap;
    assign sec_next = sec_wr ? sec_wdata : sec_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            ms_q     <= '0;
            sec_q    <= '0;
            post_ms  <= '0;
            post_sec <= '0;
        end else begin
            div_cnt <= ms_tick ? '0 : div_cnt + 1'b1;
            if (ms_tick)
                ms_q <= ms_wrap ? '0 : ms_q + 1'b1;
            if (sec_upd)
                sec_q <= sec_next;
            if (post) begin
                post_ms  <= ms_q;
                post_sec <= sec_q;
            end
        end
    end

    a_r2_ms_in_range: assert property (@(posedge clk) disable iff (rst)
        ms_q <= MS_LAST);

    a_r2_sec_moves_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sec_q) && !$past(sec_wr)) |-> ($past(ms_q) == MS_LAST && ms_q == '0));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alarm_wr,
    input  logic             mask_wr,
    input  logic             stat_wr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic             sec_upd,
    input  logic [SEC_W-1:0] sec_next,
    output logic [SEC_W-1:0] alarm_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic [IRQ_W-1:0] stat_q,
    output logic             irq
);
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[IRQ_SEC0] = sec_upd && (alarm_q != '0) && (sec_next == alarm_q);
        clr_vec = stat_wr ? wdata[IRQ_W-1:0] : '0;
    end

    assign irq = |(stat_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            mask_q  <= '0;
            stat_q  <= '0;
        end else begin
            if (alarm_wr) alarm_q <= wdata[SEC_W-1:0];
            if (mask_wr)  mask_q  <= wdata[IRQ_W-1:0];
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    a_r8_one_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wdata[IRQ_SEC0] && !set_vec[IRQ_SEC0]) |=> !stat_q[IRQ_SEC0]);

    a_r6_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_q[IRQ_SEC0] && !(stat_wr && wdata[IRQ_SEC0])) |=> stat_q[IRQ_SEC0]);

    a_r7_zero_alarm_silent: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[IRQ_SEC0]) |-> ($past(alarm_q) != '0));

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_pkg::*;
#(
    parameter int CLKS_PER_TICK  = 6104,
    parameter int TICKS_PER_POST = 8,
    parameter int CLKS_PER_MS    = 200000,
    parameter int MS_PER_SEC     = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq
);
    localparam int SEC_W = BUS_DW;
    localparam int MW    = $clog2(MS_PER_SEC);

    bus_req_t         req;
    logic             busy, post;
    logic             sec_wr, alarm_wr, mask_wr, stat_wr;
    logic [SEC_W-1:0] sec_q, sec_next, post_sec, alarm_q, shadow_q;
    logic             sec_upd;
    logic [MW-1:0]    post_ms;
    logic [IRQ_W-1:0] mask_q, stat_q;

    always_comb begin
        req.rd   = bus_sel && !bus_wr;
        req.wr   = bus_sel && bus_wr;
        req.sel  = decode_addr(bus_addr);
        req.data = bus_wdata;
    end

    // time-keeping writes are refused while posting is in progress
    assign sec_wr   = req.wr && !busy && (req.sel == REG_SEC);
    assign alarm_wr = req.wr && !busy && (req.sel == REG_ALARM);
    assign mask_wr  = req.wr && (req.sel == REG_MASK);
    assign stat_wr  = req.wr && (req.sel == REG_STAT);

    rtc_pacer #(
        .CLKS_PER_TICK (CLKS_PER_TICK),
        .TICKS_PER_POST(TICKS_PER_POST)
    ) u_pacer (
        .clk (clk),
        .rst (rst),
        .busy(busy),
        .post(post)
    );

    rtc_timebase #(
        .CLKS_PER_MS(CLKS_PER_MS),
        .MS_PER_SEC (MS_PER_SEC),
        .SEC_W      (SEC_W)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .sec_wr   (sec_wr),
        .sec_wdata(req.data),
        .post     (post),
        .sec_q    (sec_q),
        .sec_next (sec_next),
        .sec_upd  (sec_upd),
        .post_ms  (post_ms),
        .post_sec (post_sec)
    );

    rtc_alarm_irq #(
        .SEC_W(SEC_W)
    ) u_alarm (
        .clk     (clk),
        .rst     (rst),
        .alarm_wr(alarm_wr),
        .mask_wr (mask_wr),
        .stat_wr (stat_wr),
        .wdata   (req.data),
        .sec_upd (sec_upd),
        .sec_next(sec_next),
        .alarm_q (alarm_q),
        .mask_q  (mask_q),
        .stat_q  (stat_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            shadow_q  <= '0;
        end else begin
            bus_rdata <= '0;
            if (req.rd) begin
                case (req.sel)
                    REG_BUSY:   bus_rdata <= BUS_DW'(busy);
                    REG_SEC:    bus_rdata <= post_sec;
                    REG_SHADOW: bus_rdata <= shadow_q;
                    REG_MS:     bus_rdata <= BUS_DW'(post_ms);
                    REG_ALARM:  bus_rdata <= alarm_q;
                    REG_MASK:   bus_rdata <= BUS_DW'(mask_q);
                    REG_STAT:   bus_rdata <= BUS_DW'(stat_q);
                    default:    bus_rdata <= '0;
                endcase
                if (req.sel == REG_MS)
                    shadow_q <= post_sec;
            end
        end
    end

    a_r5_busy_blocks_alarm: assert property (@(posedge clk) disable iff (rst)
        (busy && req.wr && req.sel == REG_ALARM) |=> $stable(alarm_q));

    a_r4_shadow_only_on_ms_read: assert property (@(posedge clk) disable iff (rst)
        !$stable(shadow_q) |-> $past(req.rd && req.sel == REG_MS));

    a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0 && stat_q != '0));

endmodule

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;
    localparam int CPT = 2, TPP = 8, CPM = 2, MPS = 10;
    localparam int MS_PER_POST = CPT * TPP / CPM;

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;

    rtc_alarm_top #(.CLKS_PER_TICK(CPT), .TICKS_PER_POST(TPP),
                    .CLKS_PER_MS(CPM), .MS_PER_SEC(MPS)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic wait_post();
        logic [31:0] b;
        for (int i = 0; i < 100; i++) begin rd(12'h004, b); if (b[0]) break; end
        for (int i = 0; i < 100; i++) begin rd(12'h004, b); if (!b[0]) break; end
    endtask

    // returns on the negedge whose following cycle is the last busy cycle
    task automatic align_busy();
        logic [31:0] b;
        for (int i = 0; i < 100; i++) begin rd(12'h004, b); if (!b[0]) break; end
        for (int i = 0; i < 100; i++) begin rd(12'h004, b); if (b[0]) break; end
    endtask

    task automatic read_pair(output logic [31:0] s, output logic [31:0] m);
        rd(12'h010, m);
        rd(12'h00C, s);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 0);
        rd(12'h004, d); check("R1 busy", d, 0);
        rd(12'h008, d); check("R1 seconds", d, 0);
        rd(12'h00C, d); check("R1 shadow", d, 0);
        rd(12'h010, d); check("R1 ms", d, 0);
        rd(12'h014, d); check("R1 alarm", d, 0);
        rd(12'h028, d); check("R1 mask", d, 0);
        rd(12'h02C, d); check("R1 status", d, 0);
    endtask

    task automatic t_counting();
        logic [31:0] s, m, prev;
        wait_post(); read_pair(s, m);
        prev = s * MPS + m;
        for (int i = 0; i < 5; i++) begin
            wait_post(); read_pair(s, m);
            check("R2 ms below limit", {31'b0, m < MPS}, 1);
            check("R3 posting step", s * MPS + m - prev, MS_PER_POST);
            prev = s * MPS + m;
        end
    endtask

    task automatic t_shadow();
        logic [31:0] s, m, sec, s2;
        wait_post();
        rd(12'h010, m); rd(12'h008, sec); rd(12'h00C, s);
        check("R4 shadow matches posted seconds", s, sec);
        for (int i = 0; i < 3; i++) wait_post();
        rd(12'h00C, s2);
        check("R4 shadow held without ms read", s2, s);
    endtask

    task automatic t_write_ok();
        logic [31:0] s, m, d;
        wait_post();
        wr(12'h008, 32'd100);
        wr(12'h014, 32'h0000_5000);
        rd(12'h014, d); check("R5 alarm write when idle", d, 32'h0000_5000);
        wait_post(); read_pair(s, m);
        check("R5 seconds write when idle", {31'b0, s == 100 || s == 101}, 1);
        wr(12'h014, 0);
    endtask

    task automatic t_write_busy();
        logic [31:0] s, m, d;
        align_busy();
        wr(12'h014, 32'h0000_0777);
        rd(12'h014, d); check("R5 alarm write while busy ignored", d, 0);
        align_busy();
        wr(12'h008, 32'd5000);
        wait_post(); read_pair(s, m);
        check("R5 seconds write while busy ignored", {31'b0, s < 200}, 1);
    endtask

    task automatic t_alarm();
        logic [31:0] s, m, d;
        wr(12'h02C, 32'h1F); wr(12'h028, 0);
        wait_post(); read_pair(s, m);
        wr(12'h014, s + 3);
        repeat (120) @(negedge clk);
        rd(12'h02C, d); check("R6 status set on match", d, 1);
        check("R9 irq low with mask clear", {31'b0, irq}, 0);
        repeat (60) @(negedge clk);
        rd(12'h02C, d); check("R6 status sticky", d, 1);
        wr(12'h028, 32'h1E);
        check("R9 irq low with other mask bits", {31'b0, irq}, 0);
        wr(12'h028, 32'h01);
        check("R9 irq high with mask bit 0", {31'b0, irq}, 1);
        wr(12'h02C, 32'h1E);
        rd(12'h02C, d); check("R8 zero bits leave status", d, 1);
        wr(12'h02C, 32'h01);
        rd(12'h02C, d); check("R8 one clears status", d, 0);
        check("R9 irq low after clear", {31'b0, irq}, 0);
        wr(12'h014, 0);
    endtask

    task automatic t_alarm_zero();
        logic [31:0] s, m, d;
        wr(12'h014, 0); wr(12'h02C, 32'h1F); wr(12'h028, 32'h01);
        wait_post();
        wr(12'h008, 32'hFFFF_FFFF);
        repeat (60) @(negedge clk);
        wait_post(); read_pair(s, m);
        check("R2 seconds wrap to zero", {31'b0, s <= 3}, 1);
        rd(12'h02C, d); check("R7 zero alarm never fires", d, 0);
        check("R7 irq stays low", {31'b0, irq}, 0);
        wr(12'h028, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] s, m, d, t1, sh;
        rd(12'h020, d); check("R10 unmapped read", d, 0);
        rd(12'h000, d); check("R10 offset 0 read", d, 0);
        rd(12'h00C, sh);
        wr(12'h00C, 32'hDEAD_BEEF);
        rd(12'h00C, d); check("R10 shadow not writable", d, sh);
        wait_post(); read_pair(s, m); t1 = s * MPS + m;
        wr(12'h010, 32'h3); wr(12'h004, 32'h1);
        wait_post(); read_pair(s, m);
        check("R10 ms and busy not writable", s * MPS + m - t1, MS_PER_POST);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_counting();
        t_shadow();
        t_write_ok();
        t_write_busy();
        t_alarm();
        t_alarm_zero();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule